// File: doc/BRIEF.md
# Pulse Subset Selector

This block sits in a trigger path and passes on only chosen members of an incoming pulse train. Typical use is a detector or camera that must fire on a subset of position-locked encoder pulses. The chosen members are named by their zero-based ordinal after arming. These ordinals are written as an ascending list into a small internal memory, together with a count of how many list entries are valid.

The input pulse is first brought into the clock domain by a synchronizer chain. Its rising edges are then counted while the block is armed. When the running ordinal equals the list entry under the read pointer, the output copies that input pulse, with its full width, and the pointer steps on. After the last valid entry has been used, the block sits in a finished state until the arm input is dropped and raised again. Dropping arm at any time returns the block to idle, and nothing is forwarded while it is idle. The list and the count can be loaded only while the block is idle and unarmed.

Top module: `pulse_subset_gate`

## Requirements
- R1: An input pulse is forwarded only if its zero-based ordinal since arming equals the next unused list entry. A forwarded pulse keeps the width of the input pulse, and a pulse that is not forwarded leaves pulse_out low.
- R2: With the default two synchronizer stages, pulse_out rises 3 clock cycles after pulse_in is first sampled high, and falls 3 cycles after pulse_in is first sampled low.
- R3: Ordinal 0 is the first rising edge of pulse_in seen after arming. An input that is already high when arm rises is not counted.
- R4: One cycle after arm is sampled low, busy, done and pulse_out are all 0, and no pulse is forwarded while arm stays low.
- R5: When as many entries have matched as the stored length, the cycle after the last match shows done=1 and busy=0, and no further pulse is forwarded. A stored length of 0 gives done=1 and busy=0 one cycle after arming. Between arming and completion, busy=1 and done=0.
- R6: Writes are accepted only while the block is idle and arm is low. A write at any other time leaves both the list and the length unchanged.
- R7: Each new arming restarts the ordinal at 0 and the read pointer at the first entry, whatever state the previous run ended in.
- R8: A write with wr_len=1 sets the length from wr_data, limited to DEPTH. A write with wr_len=0 stores wr_data as list entry wr_addr.
- R9: The ordinal counter saturates at 2^IDX_W and never wraps. An entry below the current ordinal therefore never matches: the block stays busy and forwards nothing more.
- R10: After reset, pulse_out, busy and done are 0 and the stored length is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pulse_in | input | 1 | Asynchronous input pulse train |
| wr_en | input | 1 | Write strobe for list or length |
| wr_len | input | 1 | 1 selects the length register, 0 selects a list entry |
| wr_addr | input | $clog2(DEPTH) | List entry address |
| wr_data | input | IDX_W | Ordinal or length value |
| arm | input | 1 | High arms the block, low returns it to idle |
| pulse_out | output | 1 | Selected pulses |
| busy | output | 1 | Armed and still waiting for list entries |
| done | output | 1 | All listed pulses have been forwarded |

## Verification
The bench builds the block with DEPTH=8 and IDX_W=8. A shallow list makes a completely filled list, and a length write beyond the depth, cheap to exercise. An 8-bit ordinal lets a few hundred pulses drive the counter into saturation. That run shows that an out-of-order entry of 0 is not matched again at ordinal 256, which a wrapping counter would do. The default two synchronizer stages are kept, so the 3-cycle latency can be checked on both edges of each forwarded pulse.

// File: rtl/pss_pkg.sv
package pss_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } pss_state_e;
endpackage

// File: rtl/pss_sync_edge.sv
module pss_sync_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_i,
  output logic lvl_o,
  output logic rise_o
);
  logic [SYNC_STAGES-1:0] chain_q;
  logic                   prev_q;

  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) chain_q <= '0;
        else     chain_q <= async_i;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) chain_q <= '0;
        else     chain_q <= {chain_q[SYNC_STAGES-2:0], async_i};
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= chain_q[SYNC_STAGES-1];
  end

  assign lvl_o  = chain_q[SYNC_STAGES-1];
  assign rise_o = chain_q[SYNC_STAGES-1] & ~prev_q;
endmodule

// File: rtl/pss_index_store.sv
module pss_index_store #(
  parameter int IDX_W  = 16,
  parameter int DEPTH  = 64,
  parameter int ADDR_W = 6,
  parameter int LEN_W  = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_ok_i,
  input  logic              wr_en_i,
  input  logic              wr_len_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [IDX_W-1:0]  wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [IDX_W-1:0]  entry_o,
  output logic [LEN_W-1:0]  len_o
);
  localparam logic [IDX_W-1:0] DEPTH_V = IDX_W'(DEPTH);

  logic [IDX_W-1:0] mem [DEPTH];
  logic [IDX_W-1:0] rd_q;
  logic [LEN_W-1:0] len_q;
  logic             take;

  assign take = wr_en_i && wr_ok_i;

  always_ff @(posedge clk) begin
    if (take && !wr_len_i) mem[wr_addr_i] <= wr_data_i;
    rd_q <= mem[rd_addr_i];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      len_q <= '0;
    end else if (take && wr_len_i) begin
      if (wr_data_i > DEPTH_V) len_q <= LEN_W'(DEPTH);
      else                     len_q <= wr_data_i[LEN_W-1:0];
    end
  end

  assign entry_o = rd_q;
  assign len_o   = len_q;

  AST_LEN_LOCKED: assert property (@(posedge clk) disable iff (rst)
    (wr_en_i && !wr_ok_i) |=> $stable(len_q)); // R6
  AST_LEN_LIMIT: assert property (@(posedge clk) disable iff (rst)
    len_q <= LEN_W'(DEPTH)); // R8
endmodule

// File: rtl/pss_sequencer.sv
module pss_sequencer
  import pss_pkg::*;
#(
  parameter int IDX_W  = 16,
  parameter int ADDR_W = 6,
  parameter int LEN_W  = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              arm_i,
  input  logic              rise_i,
  input  logic              lvl_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic [IDX_W-1:0]  entry_i,
  output logic [ADDR_W-1:0] rd_addr_o,
  output logic              wr_ok_o,
  output logic              pulse_o,
  output logic              busy_o,
  output logic              done_o
);
  localparam int CNT_W = IDX_W + 1;
  localparam logic [CNT_W-1:0] CNT_TOP = {1'b1, {IDX_W{1'b0}}};

  pss_state_e       state_q, state_d;
  logic [LEN_W-1:0] ptr_q, ptr_d, ptr_inc;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             out_q, out_d;
  logic             hit;

  assign ptr_inc = ptr_q + LEN_W'(1);
  assign hit = (state_q == ST_RUN) && arm_i && rise_i && (cnt_q == {1'b0, entry_i});

  always_comb begin
    state_d = state_q;
    ptr_d   = ptr_q;
    cnt_d   = cnt_q;
    out_d   = out_q & lvl_i;
    case (state_q)
      ST_IDLE: begin
        out_d = 1'b0;
        if (arm_i) begin
          ptr_d   = '0;
          cnt_d   = '0;
          state_d = (len_i == '0) ? ST_DONE : ST_RUN;
        end
      end
      ST_RUN: begin
        if (!arm_i) begin
          state_d = ST_IDLE;
          out_d   = 1'b0;
        end else begin
          if (rise_i && cnt_q != CNT_TOP) cnt_d = cnt_q + CNT_W'(1);
          if (hit) begin
            out_d = 1'b1;
            ptr_d = ptr_inc;
            if (ptr_inc == len_i) state_d = ST_DONE;
          end
        end
      end
      ST_DONE: begin
        if (!arm_i) begin
          state_d = ST_IDLE;
          out_d   = 1'b0;
        end
      end
      default: begin
        state_d = ST_IDLE;
        out_d   = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      ptr_q   <= '0;
      cnt_q   <= '0;
      out_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      ptr_q   <= ptr_d;
      cnt_q   <= cnt_d;
      out_q   <= out_d;
    end
  end

  assign rd_addr_o = ptr_d[ADDR_W-1:0];
  assign wr_ok_o   = (state_q == ST_IDLE) && !arm_i;
  assign pulse_o   = out_q;
  assign busy_o    = (state_q == ST_RUN);
  assign done_o    = (state_q == ST_DONE);

  AST_OUT_FROM_EDGE: assert property (@(posedge clk) disable iff (rst)
    $rose(out_q) |-> $past(rise_i && arm_i)); // R1
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_IDLE) |-> !out_q); // R4
  AST_DONE_SILENT: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_DONE) |=> !$rose(out_q)); // R5
  AST_PTR_BOUND: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_RUN) |-> (ptr_q < len_i)); // R5
  AST_REARM_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (state_q != ST_IDLE && $past(state_q) == ST_IDLE) |-> (cnt_q == '0 && ptr_q == '0)); // R7
  AST_CNT_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
    ($past(cnt_q) == CNT_TOP && state_q == ST_RUN && $past(state_q) == ST_RUN) |-> (cnt_q == CNT_TOP)); // R9
endmodule

// File: rtl/pulse_subset_gate.sv
module pulse_subset_gate #(
  parameter int IDX_W       = 16,
  parameter int DEPTH       = 64,
  parameter int SYNC_STAGES = 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     pulse_in,
  input  logic                     wr_en,
  input  logic                     wr_len,
  input  logic [$clog2(DEPTH)-1:0] wr_addr,
  input  logic [IDX_W-1:0]         wr_data,
  input  logic                     arm,
  output logic                     pulse_out,
  output logic                     busy,
  output logic                     done
);
  localparam int ADDR_W = $clog2(DEPTH);
  localparam int LEN_W  = ADDR_W + 1;

  logic              lvl, rise, wr_ok;
  logic [ADDR_W-1:0] rd_addr;
  logic [IDX_W-1:0]  entry;
  logic [LEN_W-1:0]  len;

  pss_sync_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk(clk), .rst(rst), .async_i(pulse_in), .lvl_o(lvl), .rise_o(rise)
  );

  pss_index_store #(.IDX_W(IDX_W), .DEPTH(DEPTH), .ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_store (
    .clk(clk), .rst(rst), .wr_ok_i(wr_ok), .wr_en_i(wr_en), .wr_len_i(wr_len),
    .wr_addr_i(wr_addr), .wr_data_i(wr_data), .rd_addr_i(rd_addr),
    .entry_o(entry), .len_o(len)
  );

  pss_sequencer #(.IDX_W(IDX_W), .ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_seq (
    .clk(clk), .rst(rst), .arm_i(arm), .rise_i(rise), .lvl_i(lvl),
    .len_i(len), .entry_i(entry), .rd_addr_o(rd_addr), .wr_ok_o(wr_ok),
    .pulse_o(pulse_out), .busy_o(busy), .done_o(done)
  );
endmodule

// File: tb/pulse_subset_gate_bench.sv
module pulse_subset_gate_bench;
  localparam int IDX_W = 8;
  localparam int DEPTH = 8;
  localparam int AW    = $clog2(DEPTH);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pulse_in = 1'b0, wr_en = 1'b0, wr_len = 1'b0, arm = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [IDX_W-1:0] wr_data = '0;
  logic pulse_out, busy, done;
  int n_chk = 0, n_bad = 0;

  always #2 clk = ~clk;

  pulse_subset_gate #(.IDX_W(IDX_W), .DEPTH(DEPTH), .SYNC_STAGES(2)) u_pulse_subset_gate (
    .clk(clk), .rst(rst), .pulse_in(pulse_in), .wr_en(wr_en), .wr_len(wr_len),
    .wr_addr(wr_addr), .wr_data(wr_data), .arm(arm),
    .pulse_out(pulse_out), .busy(busy), .done(done)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic report();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  task automatic wr_entry(input int a, input int v);
    @(negedge clk); wr_en = 1; wr_len = 0; wr_addr = AW'(a); wr_data = IDX_W'(v);
    @(negedge clk); wr_en = 0;
  endtask

  task automatic wr_length(input int v);
    @(negedge clk); wr_en = 1; wr_len = 1; wr_data = IDX_W'(v);
    @(negedge clk); wr_en = 0; wr_len = 0;
  endtask

  task automatic set_arm(input logic v);
    @(negedge clk); arm = v;
    @(negedge clk);
  endtask

  // Drives one pulse of w cycles and measures the output window.
  task automatic send_pulse(input bit sel, input int w, input string req, input int ord);
    int hi = 0, first = 0, last = 0;
    pulse_in = 1;
    for (int s = 1; s <= w + 5; s++) begin
      @(negedge clk);
      if (pulse_out) begin
        hi++;
        if (first == 0) first = s;
        last = s;
      end
      if (s == w) pulse_in = 0;
    end
    check(req, $sformatf("ordinal %0d output cycles", ord), hi, sel ? w : 0);
    if (sel) begin
      check("R2", $sformatf("ordinal %0d rise step", ord), first, 3);
      check("R2", $sformatf("ordinal %0d fall step", ord), last + 1, w + 3);
    end
  endtask

  task automatic t_reset();
    check("R10", "pulse_out after reset", pulse_out, 0);
    check("R10", "busy after reset", busy, 0);
    check("R10", "done after reset", done, 0);
    set_arm(1);
    check("R10", "length 0 after reset gives done", done, 1);
    set_arm(0);
  endtask

  task automatic t_basic();
    wr_entry(0, 0); wr_entry(1, 2); wr_entry(2, 4); wr_entry(3, 6); wr_length(4);
    set_arm(1);
    check("R5", "busy while running", busy, 1);
    check("R5", "done while running", done, 0);
    for (int k = 0; k < 9; k++) begin
      send_pulse(k == 0 || k == 2 || k == 4 || k == 6, 1 + (k % 3) * 2, "R1", k);
      if (k == 6) begin
        check("R5", "done after last entry", done, 1);
        check("R5", "busy after last entry", busy, 0);
      end
    end
    set_arm(0);
    check("R4", "busy after disarm", busy, 0);
    check("R4", "done after disarm", done, 0);
  endtask

  task automatic t_prearmed_high();
    wr_entry(0, 0); wr_length(1);
    pulse_in = 1;
    repeat (4) @(negedge clk);
    set_arm(1);
    repeat (3) @(negedge clk);
    check("R3", "high-at-arm pulse not forwarded", pulse_out, 0);
    pulse_in = 0;
    repeat (4) @(negedge clk);
    check("R3", "busy after uncounted pulse", busy, 1);
    send_pulse(1, 4, "R3", 0);
    set_arm(0);
  endtask

  task automatic t_disarm_rearm();
    wr_entry(0, 1); wr_entry(1, 3); wr_length(2);
    set_arm(1);
    send_pulse(0, 2, "R1", 0);
    send_pulse(1, 2, "R1", 1);
    set_arm(0);
    check("R4", "busy low when disarmed", busy, 0);
    send_pulse(0, 2, "R4", 2);
    send_pulse(0, 2, "R4", 3);
    set_arm(1);
    send_pulse(0, 2, "R7", 0);
    send_pulse(1, 2, "R7", 1);
    send_pulse(0, 2, "R7", 2);
    send_pulse(1, 2, "R7", 3);
    check("R7", "done after rearmed run", done, 1);
    set_arm(0);
  endtask

  task automatic t_write_lock();
    wr_entry(0, 0); wr_length(1);
    set_arm(1);
    wr_entry(0, 5);
    wr_length(0);
    check("R6", "busy unaffected by length write", busy, 1);
    send_pulse(1, 3, "R6", 0);
    set_arm(0);
    set_arm(1);
    check("R6", "length kept after armed write", busy, 1);
    send_pulse(1, 3, "R6", 0);
    set_arm(0);
  endtask

  task automatic t_zero_len();
    wr_length(0);
    set_arm(1);
    check("R5", "zero length done", done, 1);
    check("R5", "zero length busy", busy, 0);
    send_pulse(0, 2, "R5", 0);
    set_arm(0);
  endtask

  task automatic t_full();
    for (int a = 0; a < DEPTH; a++) wr_entry(a, a);
    wr_length(DEPTH + 1);
    set_arm(1);
    for (int k = 0; k <= DEPTH; k++) send_pulse(k < DEPTH, 1, "R8", k);
    check("R8", "done after clamped length", done, 1);
    set_arm(0);
  endtask

  task automatic t_stall();
    wr_entry(0, 1); wr_entry(1, 0); wr_length(2);
    set_arm(1);
    for (int k = 0; k < 262; k++) send_pulse(k == 1, 1, "R9", k);
    check("R9", "busy while stalled", busy, 1);
    check("R9", "done while stalled", done, 0);
    set_arm(0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_basic();
    t_prearmed_high();
    t_disarm_rearm();
    t_write_lock();
    t_zero_len();
    t_full();
    t_stall();
    report();
  end
endmodule